// File: doc/BRIEF.md
# Clock Integrity Monitor with Frequency Meter

This block watches two clocks from the domain of an always-running internal reference oscillator, and it can also measure one clock against another. The PLL supervisor counts PLL edges over a fixed window of reference cycles. It flags a fault when that count goes above a programmed ceiling or below a programmed floor. The crystal supervisor counts crystal edges during each period of a divided reference. It flags a fault when the crystal is not fast enough to show at least two edges in that period. The frequency meter is started by a pulse. It counts reference cycles across a programmed number of crystal periods, then latches the result and raises a done flag.

Each fault sets a sticky status bit, and software clears that bit by writing 1 to it. The fault is also driven on a fault-collection output. A programmable action select turns the fault into exactly one request: a reset request (the value after reset), a safe-mode request or an interrupt. The monitored clocks enter through two-flop synchronizers and are edge-detected in the reference domain. For this reason they must already be divided down to at most a quarter of the reference rate.

Top module: `clk_integrity_monitor`

## Requirements
- R1: After a synchronous reset, the status bits, every request output, the fault-collection output and the meter done flag are all 0.
- R2: With the PLL monitor enabled, a window of WIN_REF reference cycles that contains more PLL rising edges than `pll_hi_i` sets status bit 0.
- R3: With the PLL monitor enabled, a window that contains fewer PLL rising edges than `pll_lo_i` sets status bit 0. A count equal to either bound does not set it.
- R4: With the crystal monitor enabled, each period of `xtal_div_i` reference cycles that contains zero or one crystal rising edge sets status bit 1. Two or more edges in the period do not set it.
- R5: A pulse on `meter_start_i` clears done and waits for a crystal rising edge. The block then counts reference cycles until `meter_win_i` further crystal edges have occurred, latches that count on `meter_count_o` and sets `meter_done_o`. Both stay unchanged until the next start.
- R6: Status bits stay set until a 1 is written to the matching bit of `status_clr_i`. A fault event in the same cycle as a clear leaves the bit set.
- R7: When any status bit is set, `fault_out_o` is 1 and `act_sel_i` picks one request: 00 drives `reset_req_o`, 01 drives `safe_req_o`, and 10 or 11 drives `irq_o`.
- R8: A monitor whose enable is 0 never sets its status bit, whatever its thresholds and input clock.
- R9: When both monitors are enabled in the same cycle, with `xtal_div_i` equal to WIN_REF and both clocks stopped, both status bits rise in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Internal reference clock, clocks every register |
| rst_ref_ni | input | 1 | Synchronous active-low reset |
| pll_clk_i | input | 1 | Divided PLL clock under supervision |
| xtal_clk_i | input | 1 | Crystal clock under supervision and meter time base |
| pll_mon_en_i | input | 1 | PLL window monitor enable |
| pll_hi_i | input | CNT_W | Highest allowed PLL edge count per window |
| pll_lo_i | input | CNT_W | Lowest allowed PLL edge count per window |
| xtal_mon_en_i | input | 1 | Crystal loss monitor enable |
| xtal_div_i | input | DIV_W | Reference division factor for the crystal check |
| meter_start_i | input | 1 | One-cycle pulse that starts a measurement |
| meter_win_i | input | MWIN_W | Crystal periods per measurement |
| act_sel_i | input | 2 | Fault response select |
| status_clr_i | input | 2 | Write-1-to-clear strobe for the status bits |
| status_o | output | 2 | Sticky fault status, bit 0 PLL, bit 1 crystal |
| reset_req_o | output | 1 | Reset request to the reset controller |
| safe_req_o | output | 1 | Safe-mode request to the mode controller |
| irq_o | output | 1 | Interrupt request |
| fault_out_o | output | 1 | Fault-collection notification |
| meter_busy_o | output | 1 | Measurement in progress |
| meter_done_o | output | 1 | Measurement finished, count valid |
| meter_count_o | output | MCNT_W | Reference cycles measured over the window |

## Verification
Two functions can fall in the same cycle: the end of a PLL window and the end of a crystal period. The bench makes them coincide by stopping both clocks, setting the crystal divider equal to the PLL window length and enabling both monitors on one edge. Both windows then begin on the same cycle and report on the same cycle. A per-cycle monitor records the cycle in which each status bit first reads 1, and the check passes only when the two recorded cycles are equal and both bits are set.

// File: rtl/cmon_pkg.sv
// Package cmon_pkg
// Shared types for the clock integrity monitor: response encoding and
// frequency meter states. Assumes nothing beyond IEEE 1800-2017.
package cmon_pkg;

    typedef enum logic [1:0] {
        ACT_RESET = 2'b00,
        ACT_SAFE  = 2'b01,
        ACT_IRQ   = 2'b10,
        ACT_IRQ_B = 2'b11
    } cmon_act_e;

    typedef enum logic [1:0] {
        MTR_IDLE = 2'b00,
        MTR_ARM  = 2'b01,
        MTR_RUN  = 2'b10
    } cmon_mtr_e;

    localparam int unsigned FLT_PLL  = 0;
    localparam int unsigned FLT_XTAL = 1;
    localparam int unsigned FLT_N    = 2;

endpackage

// File: rtl/cmon_edge_sync.sv
// Module cmon_edge_sync
// Brings a slow foreign clock into the reference domain through two flops
// and emits a one-cycle pulse per rising edge. Assumes the input toggles
// at most once every two reference cycles.
module cmon_edge_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    // Synchronizer chain plus one delay stage for edge detection
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

endmodule

// File: rtl/cmon_pll_window.sv
// Module cmon_pll_window
// Counts PLL edge pulses over WIN_REF reference cycles and raises a
// one-cycle fault event when the count is above hi or below lo.
// Assumes the thresholds are stable while enabled. Disabled means idle.
module cmon_pll_window #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned WIN_REF = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic             fault_evt_o
);
    localparam int unsigned WIN_W = (WIN_REF > 1) ? $clog2(WIN_REF) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_REF - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    logic [WIN_W-1:0] win_q;
    logic [CNT_W-1:0] edges_q;
    logic [CNT_W-1:0] total;
    logic             win_end;

    // Edge total including this cycle's pulse, saturating
    always_comb begin
        if (edges_q == CNT_MAX) total = edges_q;
        else                    total = edges_q + CNT_W'(rise_i);
    end

    assign win_end = (win_q == WIN_LAST);

    // Window sequencing, edge accumulation and bound comparison
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            win_q       <= '0;
            edges_q     <= '0;
            fault_evt_o <= 1'b0;
        end else begin
            fault_evt_o <= win_end && ((total > hi_i) || (total < lo_i));
            if (win_end) begin
                win_q   <= '0;
                edges_q <= '0;
            end else begin
                win_q   <= win_q + 1'b1;
                edges_q <= total;
            end
        end
    end

endmodule

// File: rtl/cmon_xtal_loss.sv
// Module cmon_xtal_loss
// Splits reference time into periods of div cycles (0 treated as 1) and
// raises a one-cycle fault event when a period holds fewer than two
// crystal edge pulses. Disabled means idle.
module cmon_xtal_loss #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             rise_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             fault_evt_o
);
    logic [DIV_W-1:0] per_q;
    logic [DIV_W-1:0] last;
    logic [1:0]       seen_q;
    logic [1:0]       seen_nx;
    logic             per_end;

    // Period end point and saturating edge tally
    always_comb begin
        last    = (div_i == '0) ? '0 : div_i - 1'b1;
        per_end = (per_q >= last);
        seen_nx = (seen_q == 2'd2) ? seen_q : seen_q + 2'(rise_i);
    end

    // Period counter and loss decision at each period end
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !en_i) begin
            per_q       <= '0;
            seen_q      <= '0;
            fault_evt_o <= 1'b0;
        end else begin
            fault_evt_o <= per_end && (seen_nx < 2'd2);
            if (per_end) begin
                per_q  <= '0;
                seen_q <= '0;
            end else begin
                per_q  <= per_q + 1'b1;
                seen_q <= seen_nx;
            end
        end
    end

endmodule

// File: rtl/cmon_freq_meter.sv
// Module cmon_freq_meter
// On start, aligns to a crystal edge, then counts reference cycles until
// win further crystal edges pass (0 treated as 1). Latches the count and
// holds done until the next start; a start while busy restarts.
module cmon_freq_meter
    import cmon_pkg::*;
#(
    parameter int unsigned MWIN_W = 8,
    parameter int unsigned MCNT_W = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              rise_i,
    input  logic [MWIN_W-1:0] win_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [MCNT_W-1:0] count_o
);
    localparam logic [MCNT_W-1:0] MCNT_MAX = '1;

    cmon_mtr_e         st_q;
    logic [MCNT_W-1:0] cyc_q;
    logic [MCNT_W-1:0] cyc_nx;
    logic [MWIN_W-1:0] edg_q;
    logic [MWIN_W-1:0] edg_nx;

    // Saturating next values of the cycle and edge counters
    always_comb begin
        cyc_nx = (cyc_q == MCNT_MAX) ? cyc_q : cyc_q + 1'b1;
        edg_nx = edg_q + MWIN_W'(rise_i);
    end

    // Measurement sequencer and result latch
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q    <= MTR_IDLE;
            cyc_q   <= '0;
            edg_q   <= '0;
            done_o  <= 1'b0;
            count_o <= '0;
        end else if (start_i) begin
            st_q   <= MTR_ARM;
            done_o <= 1'b0;
        end else begin
            unique case (st_q)
                MTR_ARM: begin
                    if (rise_i) begin
                        st_q  <= MTR_RUN;
                        cyc_q <= '0;
                        edg_q <= '0;
                    end
                end
                MTR_RUN: begin
                    cyc_q <= cyc_nx;
                    edg_q <= edg_nx;
                    if (rise_i && (edg_nx >= win_i)) begin
                        st_q    <= MTR_IDLE;
                        count_o <= cyc_nx;
                        done_o  <= 1'b1;
                    end
                end
                default: st_q <= MTR_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != MTR_IDLE);

endmodule

// File: rtl/cmon_fault_route.sv
// Module cmon_fault_route
// Holds the sticky fault status (set wins over write-1-to-clear) and
// turns any set bit into one request chosen by the action select.
module cmon_fault_route
    import cmon_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [FLT_N-1:0]  evt_i,
    input  logic [FLT_N-1:0]  clr_i,
    input  logic [1:0]        act_sel_i,
    output logic [FLT_N-1:0]  status_o,
    output logic              reset_req_o,
    output logic              safe_req_o,
    output logic              irq_o,
    output logic              fault_out_o
);
    cmon_act_e act;
    logic      any;

    // Sticky status register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) status_o <= '0;
        else         status_o <= (status_o & ~clr_i) | evt_i;
    end

    // Response decode
    always_comb begin
        act         = cmon_act_e'(act_sel_i);
        any         = |status_o;
        fault_out_o = any;
        reset_req_o = any && (act == ACT_RESET);
        safe_req_o  = any && (act == ACT_SAFE);
        irq_o       = any && ((act == ACT_IRQ) || (act == ACT_IRQ_B));
    end

endmodule

// File: rtl/clk_integrity_monitor.sv
// Module clk_integrity_monitor
// Top level: synchronizes the two supervised clocks, runs the PLL window
// check, the crystal loss check and the frequency meter, and routes faults.
// Assumes pll_clk_i and xtal_clk_i run at no more than a quarter of clk_ref_i.
module clk_integrity_monitor
    import cmon_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned WIN_REF = 64,
    parameter int unsigned DIV_W   = 8,
    parameter int unsigned MWIN_W  = 8,
    parameter int unsigned MCNT_W  = 20
) (
    input  logic              clk_ref_i,
    input  logic              rst_ref_ni,
    input  logic              pll_clk_i,
    input  logic              xtal_clk_i,
    input  logic              pll_mon_en_i,
    input  logic [CNT_W-1:0]  pll_hi_i,
    input  logic [CNT_W-1:0]  pll_lo_i,
    input  logic              xtal_mon_en_i,
    input  logic [DIV_W-1:0]  xtal_div_i,
    input  logic              meter_start_i,
    input  logic [MWIN_W-1:0] meter_win_i,
    input  logic [1:0]        act_sel_i,
    input  logic [1:0]        status_clr_i,
    output logic [1:0]        status_o,
    output logic              reset_req_o,
    output logic              safe_req_o,
    output logic              irq_o,
    output logic              fault_out_o,
    output logic              meter_busy_o,
    output logic              meter_done_o,
    output logic [MCNT_W-1:0] meter_count_o
);
    logic [FLT_N-1:0] clk_in;
    logic [FLT_N-1:0] rise;
    logic             pll_evt;
    logic             xtal_evt;

    assign clk_in[FLT_PLL]  = pll_clk_i;
    assign clk_in[FLT_XTAL] = xtal_clk_i;

    // One synchronizer and edge detector per supervised clock
    for (genvar g = 0; g < FLT_N; g++) begin : g_sync
        cmon_edge_sync i_sync (
            .clk_i  (clk_ref_i),
            .rst_ni (rst_ref_ni),
            .async_i(clk_in[g]),
            .rise_o (rise[g])
        );
    end

    cmon_pll_window #(.CNT_W(CNT_W), .WIN_REF(WIN_REF)) i_pll (
        .clk_i      (clk_ref_i),
        .rst_ni     (rst_ref_ni),
        .en_i       (pll_mon_en_i),
        .rise_i     (rise[FLT_PLL]),
        .hi_i       (pll_hi_i),
        .lo_i       (pll_lo_i),
        .fault_evt_o(pll_evt)
    );

    cmon_xtal_loss #(.DIV_W(DIV_W)) i_xtal (
        .clk_i      (clk_ref_i),
        .rst_ni     (rst_ref_ni),
        .en_i       (xtal_mon_en_i),
        .rise_i     (rise[FLT_XTAL]),
        .div_i      (xtal_div_i),
        .fault_evt_o(xtal_evt)
    );

    cmon_freq_meter #(.MWIN_W(MWIN_W), .MCNT_W(MCNT_W)) i_meter (
        .clk_i  (clk_ref_i),
        .rst_ni (rst_ref_ni),
        .start_i(meter_start_i),
        .rise_i (rise[FLT_XTAL]),
        .win_i  (meter_win_i),
        .busy_o (meter_busy_o),
        .done_o (meter_done_o),
        .count_o(meter_count_o)
    );

    cmon_fault_route i_route (
        .clk_i      (clk_ref_i),
        .rst_ni     (rst_ref_ni),
        .evt_i      ({xtal_evt, pll_evt}),
        .clr_i      (status_clr_i),
        .act_sel_i  (act_sel_i),
        .status_o   (status_o),
        .reset_req_o(reset_req_o),
        .safe_req_o (safe_req_o),
        .irq_o      (irq_o),
        .fault_out_o(fault_out_o)
    );

endmodule

// File: rtl/cmon_checker.sv
// Module cmon_checker
// Temporal properties of the clock integrity monitor, bound to its top.
module cmon_checker #(
    parameter int unsigned MCNT_W = 20
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              pll_en,
    input logic              xtal_en,
    input logic              pll_evt,
    input logic              xtal_evt,
    input logic [1:0]        status,
    input logic [1:0]        clr,
    input logic              rst_req,
    input logic              safe_req,
    input logic              irq,
    input logic              fault_out,
    input logic              meter_start,
    input logic              meter_done,
    input logic [MCNT_W-1:0] meter_count
);
    // R2: a PLL fault event always lands in the status, even under a clear
    a_r2_pll_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pll_evt |=> status[0]);

    // R4: a crystal fault event always lands in the status
    a_r4_xtal_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        xtal_evt |=> status[1]);

    // R5: a finished measurement holds its count until restarted
    a_r5_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (meter_done && !meter_start) |=> (meter_done && $stable(meter_count)));

    // R6: a set bit without a clear stays set
    a_r6_pll_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status[0] && !clr[0]) |=> status[0]);
    a_r6_xtal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status[1] && !clr[1]) |=> status[1]);

    // R7: never more than one response at a time
    a_r7_one_action: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rst_req, safe_req, irq}));

    // R7: a fault notification always comes with a response
    a_r7_fault_routed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_out |-> (rst_req || safe_req || irq));

    // R8: disabled monitors stay silent
    a_r8_pll_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pll_en |=> !pll_evt);
    a_r8_xtal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !xtal_en |=> !xtal_evt);

endmodule

bind clk_integrity_monitor cmon_checker #(.MCNT_W(MCNT_W)) i_cmon_checker (
    .clk_i      (clk_ref_i),
    .rst_ni     (rst_ref_ni),
    .pll_en     (pll_mon_en_i),
    .xtal_en    (xtal_mon_en_i),
    .pll_evt    (pll_evt),
    .xtal_evt   (xtal_evt),
    .status     (status_o),
    .clr        (status_clr_i),
    .rst_req    (reset_req_o),
    .safe_req   (safe_req_o),
    .irq        (irq_o),
    .fault_out  (fault_out_o),
    .meter_start(meter_start_i),
    .meter_done (meter_done_o),
    .meter_count(meter_count_o)
);

// File: tb/test_clk_integrity_monitor.sv
// Scoreboard bench for clk_integrity_monitor.
module test_clk_integrity_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 16, WIN_REF = 64, DIV_W = 8, MWIN_W = 8, MCNT_W = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pll_clk = 1'b0, xtal_clk = 1'b0;
    logic pll_en = 1'b0, xtal_en = 1'b0;
    logic [CNT_W-1:0] pll_hi = '0, pll_lo = '0;
    logic [DIV_W-1:0] xdiv = 8'd16;
    logic meter_start = 1'b0;
    logic [MWIN_W-1:0] meter_win = '0;
    logic [1:0] act_sel = 2'b00, clr = 2'b00;
    logic [1:0] status;
    logic reset_req, safe_req, irq, fault_out, m_busy, m_done;
    logic [MCNT_W-1:0] m_count;

    int pll_half = 0, xtal_half = 0, pll_ph = 0, xtal_ph = 0;
    int n_checks = 0, n_fail = 0;
    int exp_q[$];
    logic done_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_integrity_monitor #(.CNT_W(CNT_W), .WIN_REF(WIN_REF), .DIV_W(DIV_W),
        .MWIN_W(MWIN_W), .MCNT_W(MCNT_W)) i_clk_integrity_monitor (
        .clk_ref_i(clk), .rst_ref_ni(rst_n), .pll_clk_i(pll_clk),
        .xtal_clk_i(xtal_clk), .pll_mon_en_i(pll_en), .pll_hi_i(pll_hi),
        .pll_lo_i(pll_lo), .xtal_mon_en_i(xtal_en), .xtal_div_i(xdiv),
        .meter_start_i(meter_start), .meter_win_i(meter_win),
        .act_sel_i(act_sel), .status_clr_i(clr), .status_o(status),
        .reset_req_o(reset_req), .safe_req_o(safe_req), .irq_o(irq),
        .fault_out_o(fault_out), .meter_busy_o(m_busy),
        .meter_done_o(m_done), .meter_count_o(m_count));

    // Slow square-wave generators, half period in reference cycles (0 = stopped)
    always @(negedge clk) begin
        if (pll_half == 0) pll_ph = 0;
        else if (pll_ph >= pll_half - 1) begin pll_ph = 0; pll_clk = ~pll_clk; end
        else pll_ph++;
        if (xtal_half == 0) xtal_ph = 0;
        else if (xtal_ph >= xtal_half - 1) begin xtal_ph = 0; xtal_clk = ~xtal_clk; end
        else xtal_ph++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        pll_en = 1'b0; xtal_en = 1'b0;
        cyc(2); clr = 2'b11; cyc(1); clr = 2'b00; cyc(1);
    endtask

    // Driver: queue the expected count, then run one measurement
    task automatic meter_run(input int win, input int expv);
        exp_q.push_back(expv);
        meter_win = MWIN_W'(win);
        meter_start = 1'b1; cyc(1); meter_start = 1'b0;
        for (int i = 0; i < 4000 && !m_done; i++) cyc(1);
        cyc(2);
    endtask

    // Monitor: pop and compare on each new done
    always @(negedge clk) begin
        if (rst_n && m_done && !done_prev) begin
            if (exp_q.size() == 0) check(1'b0, "R5 unexpected done", 1, 0);
            else begin
                int e;
                e = exp_q.pop_front();
                check(int'(m_count) == e, "R5 meter count", int'(m_count), e);
            end
        end
        done_prev = m_done;
    end

    // Watchdog
    initial begin
        cyc(150000);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int t_pll, t_xtal;
        cyc(5); rst_n = 1'b1; cyc(1);
        check(status == 2'b00, "R1 status", status, 0);
        check({reset_req, safe_req, irq} == 3'b000, "R1 requests", {reset_req, safe_req, irq}, 0);
        check(fault_out == 1'b0, "R1 fault out", fault_out, 0);
        check(m_done == 1'b0, "R1 meter done", m_done, 0);

        // R2: 16 edges per window against a ceiling of 10
        pll_half = 2; pll_lo = 0; pll_hi = 10; pll_en = 1'b1; cyc(200);
        check(status[0] == 1'b1, "R2 over ceiling", status[0], 1);
        check(reset_req == 1'b1, "R7 default reset", reset_req, 1);
        // R6: fix the bounds, bit stays set
        pll_hi = 18; pll_lo = 14; cyc(200);
        check(status[0] == 1'b1, "R6 sticky", status[0], 1);
        clear_all();
        check(status == 2'b00, "R6 write-1 clear", status, 0);

        // R3: boundary, count equal to both bounds is fine
        pll_hi = 16; pll_lo = 16; pll_en = 1'b1; cyc(300);
        check(status[0] == 1'b0, "R3 equal bounds", status[0], 0);
        pll_hi = 40; pll_lo = 20; cyc(200);
        check(status[0] == 1'b1, "R3 under floor", status[0], 1);

        // R7: response select
        act_sel = 2'b01; cyc(1);
        check({reset_req, safe_req, irq} == 3'b010, "R7 safe", {reset_req, safe_req, irq}, 2);
        act_sel = 2'b10; cyc(1);
        check({reset_req, safe_req, irq} == 3'b001, "R7 irq", {reset_req, safe_req, irq}, 1);
        act_sel = 2'b11; cyc(1);
        check(irq == 1'b1 && fault_out == 1'b1, "R7 irq alt and fault out", {irq, fault_out}, 3);
        act_sel = 2'b00;
        clear_all();

        // R8: disabled PLL monitor with impossible bounds
        pll_hi = 0; pll_lo = 100; cyc(300);
        check(status[0] == 1'b0 && fault_out == 1'b0, "R8 pll disabled", status[0], 0);

        // R4: crystal checks with a 16-cycle period
        xdiv = 16; xtal_half = 2; xtal_en = 1'b1; cyc(200);
        check(status[1] == 1'b0, "R4 fast crystal", status[1], 0);
        xtal_half = 4; cyc(200);
        check(status[1] == 1'b0, "R4 two edges pass", status[1], 0);
        xtal_half = 8; cyc(200);
        check(status[1] == 1'b1, "R4 one edge fails", status[1], 1);
        clear_all();
        xtal_half = 0; xtal_en = 1'b1; cyc(100);
        check(status[1] == 1'b1, "R4 stopped crystal", status[1], 1);
        clear_all();
        cyc(200);
        check(status[1] == 1'b0, "R8 xtal disabled", status[1], 0);

        // R5: frequency meter through the scoreboard
        xtal_half = 4; cyc(20); meter_run(5, 40);
        xtal_half = 2; cyc(20); meter_run(10, 40);
        xtal_half = 5; cyc(20); meter_run(3, 30);
        check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);

        // R9: aligned windows, both clocks stopped, both faults together
        clear_all();
        pll_half = 0; xtal_half = 0; pll_lo = 14; pll_hi = 18; xdiv = 8'(WIN_REF);
        cyc(10);
        clr = 2'b11; cyc(1); clr = 2'b00;
        pll_en = 1'b1; xtal_en = 1'b1;
        t_pll = -1; t_xtal = -1;
        for (int i = 0; i < 200; i++) begin
            cyc(1);
            if (t_pll < 0 && status[0]) t_pll = i;
            if (t_xtal < 0 && status[1]) t_xtal = i;
        end
        check(t_pll >= 0 && t_xtal >= 0, "R9 both raised", {t_pll >= 0, t_xtal >= 0}, 3);
        check(t_pll == t_xtal, "R9 same cycle", t_pll, t_xtal);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule